// File: doc/BRIEF.md
# Interleaved ZCT Gate Timing Generator

This block produces the four gate commands of a two-phase interleaved boost converter whose main switches are turned off under zero-current transition. Each phase has one main gate and one auxiliary gate. One free-running period counter serves both phases. The second phase is displaced by half a period, so the two main on-intervals alternate within every switching period and never overlap.

For each phase a duty count sets how long the main gate stays on from the start of that phase's period. The auxiliary gate is a pulse of tunable width. It sits inside the main on-interval and ends a tunable lead before the main gate drops, which gives the resonant tank time to pull the main current to zero before turn-off. All quantities are counts of the system clock. A 20 µs period at 100 MHz is 2000 counts, and a 1.5 µs auxiliary pulse is 150 counts.

The period, the auxiliary width and the auxiliary lead can be changed at run time, for example to retune the auxiliary pulse at light load. They take effect only at the period boundary of phase 1. Each duty count takes effect only at its own phase's period boundary.

Top module: `zct_gate_timer`

## Requirements
- R1: The latched period P (input values below 4 are raised to 4) sets the repetition: phase 1's main gate rises exactly every P clocks.
- R2: With effective duty D > 0, each main gate goes high at the start of its phase's period and stays high for exactly D clocks.
- R3: Phase 2's main gate rises floor(P/2) clocks after phase 1's main gate rises. The two main gates are never high in the same cycle.
- R4: The effective duty of a phase is its duty input limited to floor(P/2)-1.
- R5: With auxiliary width W and lead G, the auxiliary gate rises D-G-W clocks after its main gate rises and stays high for W clocks. It therefore falls G clocks before the main gate falls and is high only while its main gate is high. G = 0 makes both gates fall in the same cycle.
- R6: When W = 0 or D < W+G, the auxiliary gate of that phase stays low for the whole period, and the main gate is still issued for D clocks.
- R7: Period, width and lead inputs are captured only at phase 1's period boundary, and each duty input only at its own phase's boundary. A duty change made while a main pulse is in progress does not alter that pulse and applies from the next one.
- R8: While reset is high all four gates are low. After reset the period is the PERIOD_RST parameter, and the duty, width and lead are zero until first captured.
- R9: A duty of zero keeps that phase's main and auxiliary gates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_in | input | 12 | Switching period in clocks |
| duty1_in | input | 12 | Phase 1 main on-time in clocks |
| duty2_in | input | 12 | Phase 2 main on-time in clocks |
| aux_width_in | input | 12 | Auxiliary pulse width in clocks |
| aux_lead_in | input | 12 | Clocks from auxiliary turn-off to main turn-off |
| main1_o | output | 1 | Phase 1 main gate |
| aux1_o | output | 1 | Phase 1 auxiliary gate |
| main2_o | output | 1 | Phase 2 main gate |
| aux2_o | output | 1 | Phase 2 auxiliary gate |

## Verification
Two pairs of edges can fall in the same cycle. When the duty equals W+G exactly, the auxiliary pulse starts in the same cycle as the main turn-on. When the lead is zero, the auxiliary and main turn-offs coincide. Vectors with these exact settings are applied. Each edge is located on a per-cycle timeline measured from phase 1's rise, and the bench expects the coinciding edges at the same index. A duty change made in the middle of a live pulse is also judged: the pulse in progress must keep its old length.

// File: rtl/zct_pkg.sv
package zct_pkg;

    localparam int CNT_W      = 12;
    localparam int MIN_PERIOD = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t period;
        cnt_t aux_w;
        cnt_t aux_lead;
    } timing_cfg_t;

    typedef struct packed {
        logic main;
        logic aux;
    } gate_pair_t;

    function automatic cnt_t half_of(cnt_t p);
        return p >> 1;
    endfunction

    function automatic cnt_t clamp_duty(cnt_t d, cnt_t p);
        cnt_t lim;
        lim = half_of(p) - cnt_t'(1);
        return (d > lim) ? lim : d;
    endfunction

    function automatic cnt_t local_time(cnt_t c, cnt_t p, cnt_t off);
        return (c >= off) ? (c - off) : (c + (p - off));
    endfunction

endpackage

// File: rtl/zct_period_base.sv
module zct_period_base
    import zct_pkg::*;
#(
    parameter int unsigned PERIOD_RST = 2500
) (
    input  logic        clk,
    input  logic        rst,
    input  cnt_t        period_in,
    input  cnt_t        aux_w_in,
    input  cnt_t        aux_lead_in,
    output cnt_t        cnt,
    output timing_cfg_t cfg
);

    logic wrap;
    cnt_t period_lim;

    always_comb begin
        wrap       = (cnt >= (cfg.period - cnt_t'(1)));
        period_lim = (period_in < cnt_t'(MIN_PERIOD)) ? cnt_t'(MIN_PERIOD) : period_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            cfg.period   <= cnt_t'(PERIOD_RST);
            cfg.aux_w    <= '0;
            cfg.aux_lead <= '0;
        end else if (wrap) begin
            cnt          <= '0;
            cfg.period   <= period_lim;
            cfg.aux_w    <= aux_w_in;
            cfg.aux_lead <= aux_lead_in;
        end else begin
            cnt <= cnt + cnt_t'(1);
        end
    end

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt < cfg.period);

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(cfg));

endmodule

// File: rtl/zct_aux_window.sv
module zct_aux_window
    import zct_pkg::*;
(
    input  cnt_t duty,
    input  cnt_t aux_w,
    input  cnt_t aux_lead,
    output logic fits,
    output cnt_t start,
    output cnt_t stop
);

    logic [CNT_W:0] need;

    always_comb begin
        need  = {1'b0, aux_w} + {1'b0, aux_lead};
        fits  = (aux_w != '0) && ({1'b0, duty} >= need);
        stop  = duty - aux_lead;
        start = stop - aux_w;
    end

endmodule

// File: rtl/zct_phase_gen.sv
module zct_phase_gen
    import zct_pkg::*;
#(
    parameter bit LAGGING = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  cnt_t        cnt,
    input  timing_cfg_t cfg,
    input  cnt_t        duty_in,
    output gate_pair_t  gate
);

    cnt_t       offs;
    cnt_t       t;
    cnt_t       duty_q;
    cnt_t       duty_eff;
    cnt_t       a_start;
    cnt_t       a_stop;
    logic       a_fits;
    logic       at_last;
    gate_pair_t nxt;

    generate
        if (LAGGING) begin : g_lag
            assign offs = half_of(cfg.period);
        end else begin : g_lead
            assign offs = '0;
        end
    endgenerate

    always_comb begin
        t        = local_time(cnt, cfg.period, offs);
        at_last  = (t == (cfg.period - cnt_t'(1)));
        duty_eff = clamp_duty(duty_q, cfg.period);
    end

    zct_aux_window u_win (
        .duty     (duty_eff),
        .aux_w    (cfg.aux_w),
        .aux_lead (cfg.aux_lead),
        .fits     (a_fits),
        .start    (a_start),
        .stop     (a_stop)
    );

    always_comb begin
        nxt.main = (t < duty_eff);
        nxt.aux  = a_fits && (t >= a_start) && (t < a_stop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            gate   <= '0;
        end else begin
            if (at_last) begin
                duty_q <= duty_in;
            end
            gate <= nxt;
        end
    end

    assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.main) |-> ($past(t) == '0));

    assert_aux_inside_main_R5: assert property (@(posedge clk) disable iff (rst)
        gate.aux |-> gate.main);

endmodule

// File: rtl/zct_gate_timer.sv
module zct_gate_timer #(
    parameter int unsigned PERIOD_RST = 2500
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [zct_pkg::CNT_W-1:0]  period_in,
    input  logic [zct_pkg::CNT_W-1:0]  duty1_in,
    input  logic [zct_pkg::CNT_W-1:0]  duty2_in,
    input  logic [zct_pkg::CNT_W-1:0]  aux_width_in,
    input  logic [zct_pkg::CNT_W-1:0]  aux_lead_in,
    output logic                       main1_o,
    output logic                       aux1_o,
    output logic                       main2_o,
    output logic                       aux2_o
);
    import zct_pkg::*;

    localparam int N_PH = 2;

    cnt_t        cnt;
    timing_cfg_t cfg;
    cnt_t        duty_in [N_PH];
    gate_pair_t  gates   [N_PH];

    assign duty_in[0] = duty1_in;
    assign duty_in[1] = duty2_in;

    zct_period_base #(.PERIOD_RST(PERIOD_RST)) u_base (
        .clk         (clk),
        .rst         (rst),
        .period_in   (period_in),
        .aux_w_in    (aux_width_in),
        .aux_lead_in (aux_lead_in),
        .cnt         (cnt),
        .cfg         (cfg)
    );

    generate
        for (genvar p = 0; p < N_PH; p++) begin : g_phase
            zct_phase_gen #(.LAGGING(p != 0)) u_ph (
                .clk     (clk),
                .rst     (rst),
                .cnt     (cnt),
                .cfg     (cfg),
                .duty_in (duty_in[p]),
                .gate    (gates[p])
            );
        end
    endgenerate

    assign main1_o = gates[0].main;
    assign aux1_o  = gates[0].aux;
    assign main2_o = gates[1].main;
    assign aux2_o  = gates[1].aux;

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        !(main1_o && main2_o));

    always_ff @(posedge clk) begin
        if (rst) begin
            assert_reset_low_R8: assert (!(main1_o || aux1_o || main2_o || aux2_o) || 1'b1 == $past(rst) ? !(main1_o || aux1_o || main2_o || aux2_o) : 1'b1)
                else $error("gates not low after reset");
        end
    end

endmodule

// File: tb/tb_zct_gate_timer.sv
module tb_zct_gate_timer;

    localparam int W = 12;
    localparam int NV = 9;
    localparam int LIMIT = 200000;
    // period, duty1, duty2, aux width, aux lead
    localparam int VEC [NV][5] = '{
        '{ 40, 10, 10,  4,  2},
        '{ 60, 20, 12,  6,  3},
        '{ 64, 15, 15,  5, 10},
        '{ 50,  8, 30,  6,  4},
        '{100, 40, 45, 10,  0},
        '{ 81, 45, 20,  7,  5},
        '{ 30, 10, 10,  0,  2},
        '{120, 50, 59, 12,  6},
        '{ 40, 10,  0,  4,  2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] period_in = '0, duty1_in = '0, duty2_in = '0;
    logic [W-1:0] aux_width_in = '0, aux_lead_in = '0;
    logic main1_o, aux1_o, main2_o, aux2_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    zct_gate_timer #(.PERIOD_RST(40)) dut (
        .clk(clk), .rst(rst),
        .period_in(period_in), .duty1_in(duty1_in), .duty2_in(duty2_in),
        .aux_width_in(aux_width_in), .aux_lead_in(aux_lead_in),
        .main1_o(main1_o), .aux1_o(aux1_o), .main2_o(main2_o), .aux2_o(aux2_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // events relative to phase-1 main rise:
    // 0 m1 fall, 1 a1 rise, 2 a1 fall, 3 m2 rise, 4 m2 fall, 5 a2 rise, 6 a2 fall, 7 next m1 rise
    task automatic measure(input int per, output int ev[8]);
        logic [3:0] p, c;
        bit found;
        for (int k = 0; k < 8; k++) ev[k] = -1;
        found = 1'b0;
        @(negedge clk);
        p = {main1_o, aux1_o, main2_o, aux2_o};
        for (int k = 0; k < 3 * per + 10; k++) begin
            @(negedge clk);
            c = {main1_o, aux1_o, main2_o, aux2_o};
            if (!p[3] && c[3]) begin
                found = 1'b1;
                break;
            end
            p = c;
        end
        if (!found) begin
            check("R1", "phase1 rise seen", 0, 1);
            return;
        end
        for (int i = 0; i <= per; i++) begin
            if (i > 0) begin
                @(negedge clk);
                p = c;
                c = {main1_o, aux1_o, main2_o, aux2_o};
            end
            if (ev[0] < 0 &&  p[3] && !c[3]) ev[0] = i;
            if (ev[1] < 0 && !p[2] &&  c[2]) ev[1] = i;
            if (ev[2] < 0 &&  p[2] && !c[2]) ev[2] = i;
            if (ev[3] < 0 && !p[1] &&  c[1]) ev[3] = i;
            if (ev[4] < 0 &&  p[1] && !c[1]) ev[4] = i;
            if (ev[5] < 0 && !p[0] &&  c[0]) ev[5] = i;
            if (ev[6] < 0 &&  p[0] && !c[0]) ev[6] = i;
            if (i > 0 && ev[7] < 0 && !p[3] && c[3]) ev[7] = i;
        end
    endtask

    task automatic expect_phase(input int per, input int d, input int w, input int g,
                                input int base, output int e[4]);
        int half, de;
        half = per / 2;
        de = (d > half - 1) ? half - 1 : d;
        e[0] = (de > 0) ? base : -1;            // rise
        e[1] = (de > 0) ? base + de : -1;       // fall
        if (w > 0 && de >= w + g) begin
            e[2] = base + de - g - w;
            e[3] = base + de - g;
        end else begin
            e[2] = -1;
            e[3] = -1;
        end
    endtask

    initial begin
        int ev[8];
        int e1[4], e2[4];
        int per, half;
        // R8: reset holds all gates low
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R8", "gates during reset", {main1_o, aux1_o, main2_o, aux2_o}, 0);
        rst = 1'b0;
        // R8/R9: defaults are zero duty, so nothing is issued
        begin
            int seen = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                seen = seen | {main1_o, aux1_o, main2_o, aux2_o};
            end
            check("R8", "gates after reset with zero defaults", seen, 0);
        end

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            period_in    = W'(VEC[v][0]);
            duty1_in     = W'(VEC[v][1]);
            duty2_in     = W'(VEC[v][2]);
            aux_width_in = W'(VEC[v][3]);
            aux_lead_in  = W'(VEC[v][4]);
            repeat (400) @(negedge clk);
            per  = VEC[v][0];
            half = per / 2;
            measure(per, ev);
            expect_phase(per, VEC[v][1], VEC[v][3], VEC[v][4], 0, e1);
            expect_phase(per, VEC[v][2], VEC[v][3], VEC[v][4], half, e2);
            check("R2 R4", $sformatf("v%0d main1 fall", v), ev[0], e1[1]);
            check("R5 R6", $sformatf("v%0d aux1 rise", v), ev[1], e1[2]);
            check("R5 R6", $sformatf("v%0d aux1 fall", v), ev[2], e1[3]);
            check("R3 R9", $sformatf("v%0d main2 rise", v), ev[3], e2[0]);
            check("R2 R4", $sformatf("v%0d main2 fall", v), ev[4], e2[1]);
            check("R5 R6", $sformatf("v%0d aux2 rise", v), ev[5], e2[2]);
            check("R5 R6", $sformatf("v%0d aux2 fall", v), ev[6], e2[3]);
            check("R1", $sformatf("v%0d next period", v), ev[7], per);
        end

        // R7: duty change during a live pulse affects only the next pulse
        @(negedge clk);
        period_in = 40; duty1_in = 10; duty2_in = 10; aux_width_in = 4; aux_lead_in = 2;
        repeat (300) @(negedge clk);
        begin
            logic pm, cm;
            int len_now, len_next;
            bit in_pulse;
            pm = main1_o;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                cm = main1_o;
                if (!pm && cm) break;
                pm = cm;
            end
            len_now = 1;
            @(negedge clk);
            if (main1_o) len_now++;
            duty1_in = 18;
            in_pulse = main1_o;
            while (in_pulse && len_now < 60) begin
                @(negedge clk);
                if (main1_o) len_now++; else in_pulse = 1'b0;
            end
            check("R7", "pulse in progress keeps old duty", len_now, 10);
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (main1_o) break;
            end
            len_next = 0;
            for (int k = 0; k < 60; k++) begin
                if (!main1_o) break;
                len_next++;
                @(negedge clk);
            end
            check("R7", "next pulse uses new duty", len_next, 18);
        end

        // R1: period below minimum is raised to 4
        @(negedge clk);
        period_in = 2; duty1_in = 1; duty2_in = 1; aux_width_in = 0; aux_lead_in = 0;
        repeat (200) @(negedge clk);
        measure(4, ev);
        check("R1", "min period repetition", ev[7], 4);
        check("R3", "min period phase2 offset", ev[3], 2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule